// File: doc/BRIEF.md
# Programmable Memory Strobe Timing Sequencer

This block sequences the control strobes of an external parallel memory for one access or a burst of beats. A request carries a read/write flag, a burst length, a chip-select index and byte enables. The block counts functional-clock ticks from the start of the access. It places every strobe edge at a tick position taken from a set of timing inputs. It ends the access at the programmed cycle length and then reports completion with a one-clock pulse.

All timing inputs are tick counts. Each one is multiplied by a common scale factor before it is compared with the tick counter. A burst lengthens the chip-select window and the cycle by a fixed step per extra beat. Each strobe can also be pushed half a functional-clock period later. Bus-clock generation, wait handling, the address/data datapath and pad timing belong to neighbouring blocks. The timing inputs must be held stable while an access is in flight.

Top module: `mem_strobe_seq`

## Requirements
- R1: With scale S = cfg_gran+1, and with ticks numbered from 0 in the first cycle after the accepting clock edge, the address-valid strobe is active (low) on ticks t where on×S ≤ t < off×S. The chip select uses the same rule. Output enable uses it on reads only, and write enable on writes only.
- R2: The chip-select and address-valid windows close at separate points for reads and for writes. Output enable and write enable each have one on point and one off point.
- R3: Every timing value, including the cycle length and the per-beat step, is multiplied by S. The done pulse rises exactly end clock edges after the accepting edge, where end = max(1, (cycle + (beats−1)×step)×S).
- R4: A burst of n beats (req_beats_m1 = n−1) moves the chip-select close point and the cycle end later by (n−1)×cfg_beat_step×S ticks. The address-valid, output-enable and write-enable windows do not move.
- R5: cfg_half_dly bit 0 controls chip select, bit 1 address-valid, bit 2 output enable and data direction, and bit 3 write enable. A set bit moves both edges of that strobe half a functional-clock period later.
- R6: The byte-enable outputs drive the inverted request byte enables on every tick of the access, starting at tick 0. They are all ones outside an access.
- R7: dir_in goes high at the same moment output enable asserts on a read, with the same half-tick option. It stays high until the cycle end.
- R8: Of the four chip-select lines, only the one at req_cs is driven low during an access. At most one line is ever low.
- R9: In the cycle after the last tick, every strobe, byte enable and dir_in is inactive, and done is high for exactly one clock.
- R10: A request that arrives while an access is in flight is ignored.
- R11: Output enable and dir_in never assert during a write. Write enable never asserts during a read.
- R12: After reset every chip select, strobe and byte enable is inactive (high), and dir_in and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_beats_m1 | input | LW | Burst beats minus one |
| req_cs | input | CSW | Chip-select index |
| req_be | input | BEW | Byte enables (active high) |
| cfg_gran | input | GW | Time-scale field, scale = value + 1 |
| cfg_cs_on | input | TW | Chip-select assert tick |
| cfg_cs_rd_off | input | TW | Chip-select deassert tick, reads |
| cfg_cs_wr_off | input | TW | Chip-select deassert tick, writes |
| cfg_adv_on | input | TW | Address-valid assert tick |
| cfg_adv_rd_off | input | TW | Address-valid deassert tick, reads |
| cfg_adv_wr_off | input | TW | Address-valid deassert tick, writes |
| cfg_oe_on | input | TW | Output-enable assert tick |
| cfg_oe_off | input | TW | Output-enable deassert tick |
| cfg_we_on | input | TW | Write-enable assert tick |
| cfg_we_off | input | TW | Write-enable deassert tick |
| cfg_rd_cycle | input | TW | Read cycle length |
| cfg_wr_cycle | input | TW | Write cycle length |
| cfg_beat_step | input | TW | Extra ticks per additional beat |
| cfg_half_dly | input | 4 | Half-tick delay per strobe |
| cs_n | output | NCS | Chip selects, active low |
| adv_n | output | 1 | Address valid, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| be_n | output | BEW | Byte enables, active low |
| dir_in | output | 1 | Data bus input direction |
| done | output | 1 | One-clock completion pulse |

## Verification
The assertions check the invariants on every clock: at most one chip select is low, the done pulse is single and every output is quiet during it, byte enables and chip-select index hold steady through an access, read and write strobes never overlap, dir_in covers output enable, and the falling-edge copy of each strobe trails the rising-edge copy. Only the bench scenarios can show the exact tick positions of each edge, the scaling, the burst extension and the half-tick shift. The bench checks them against a tick-level model at both clock phases, using a range of scale factors, burst lengths, delay masks and a request issued mid-access.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  // Window slots; dir shares the output-enable delay bit.
  typedef enum logic [2:0] {
    SLOT_CS  = 3'd0,
    SLOT_ADV = 3'd1,
    SLOT_OE  = 3'd2,
    SLOT_WE  = 3'd3,
    SLOT_DIR = 3'd4
  } slot_e;
  localparam int NDLY  = 4;
  localparam int NSLOT = 5;
endpackage

// File: rtl/strobe_tick_ctr.sv
module strobe_tick_ctr #(
  parameter int SW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] end_tick,
  output logic          busy_q,
  output logic          busy_nxt,
  output logic [SW-1:0] tick_nxt,
  output logic          done_q
);
  logic [SW-1:0] tick_q;
  logic          last;
  logic          done_nxt;
  logic          ce;

  always_comb begin
    last     = (tick_q + SW'(1)) >= end_tick;
    busy_nxt = busy_q;
    tick_nxt = tick_q;
    if (busy_q) begin
      if (last) begin
        busy_nxt = 1'b0;
        tick_nxt = '0;
      end else begin
        tick_nxt = tick_q + SW'(1);
      end
    end else if (start) begin
      busy_nxt = 1'b1;
      tick_nxt = '0;
    end
    done_nxt = busy_q && last;
    ce       = busy_q || start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tick_q <= '0;
    end else if (ce) begin
      busy_q <= busy_nxt;
      tick_q <= tick_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_nxt;
  end

  AST_TICK_BELOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (tick_q < end_tick)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
endmodule

// File: rtl/strobe_win.sv
module strobe_win #(
  parameter int SW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          busy_q,
  input  logic          busy_nxt,
  input  logic [SW-1:0] tick_nxt,
  input  logic [SW-1:0] on_t,
  input  logic [SW-1:0] off_t,
  input  logic          half,
  output logic          act
);
  logic act_nxt;
  logic act_r;
  logic act_f;
  logic ce;

  always_comb begin
    act_nxt = en && busy_nxt && (tick_nxt >= on_t) && (tick_nxt < off_t);
    ce      = busy_q || busy_nxt || act_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  act_r <= 1'b0;
    else if (ce) act_r <= act_nxt;
  end

  // Falling-edge copy gives the half-tick late version.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) act_f <= 1'b0;
    else        act_f <= act_r;
  end

  assign act = half ? act_f : act_r;

  AST_FALL_TRAILS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    act_f == act_r); // R5
endmodule

// File: rtl/mem_strobe_seq.sv
module mem_strobe_seq
  import strobe_pkg::*;
#(
  parameter int TW  = 5,
  parameter int GW  = 2,
  parameter int LW  = 3,
  parameter int NCS = 4,
  parameter int BEW = 2,
  localparam int CSW = $clog2(NCS),
  localparam int SW  = TW + LW + 1 + GW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            req_wr,
  input  logic [LW-1:0]   req_beats_m1,
  input  logic [CSW-1:0]  req_cs,
  input  logic [BEW-1:0]  req_be,
  input  logic [GW-1:0]   cfg_gran,
  input  logic [TW-1:0]   cfg_cs_on,
  input  logic [TW-1:0]   cfg_cs_rd_off,
  input  logic [TW-1:0]   cfg_cs_wr_off,
  input  logic [TW-1:0]   cfg_adv_on,
  input  logic [TW-1:0]   cfg_adv_rd_off,
  input  logic [TW-1:0]   cfg_adv_wr_off,
  input  logic [TW-1:0]   cfg_oe_on,
  input  logic [TW-1:0]   cfg_oe_off,
  input  logic [TW-1:0]   cfg_we_on,
  input  logic [TW-1:0]   cfg_we_off,
  input  logic [TW-1:0]   cfg_rd_cycle,
  input  logic [TW-1:0]   cfg_wr_cycle,
  input  logic [TW-1:0]   cfg_beat_step,
  input  logic [NDLY-1:0] cfg_half_dly,
  output logic [NCS-1:0]  cs_n,
  output logic            adv_n,
  output logic            oe_n,
  output logic            we_n,
  output logic [BEW-1:0]  be_n,
  output logic            dir_in,
  output logic            done
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic           busy_q, busy_nxt;
  logic [SW-1:0]  tick_nxt;
  logic           start;
  logic           wr_q, wr_nxt;
  logic [LW-1:0]  len_q, len_nxt;
  logic [CSW-1:0] sel_q, sel_nxt;
  logic [BEW-1:0] be_q, be_nxt;
  logic [SW-1:0]  scale, ext, end_tick, cyc_raw;
  logic [SW-1:0]  on_a  [NSLOT];
  logic [SW-1:0]  off_a [NSLOT];
  logic           en_a  [NSLOT];
  logic           half_a[NSLOT];
  logic           act_a [NSLOT];

  function automatic logic [SW-1:0] zx(input logic [TW-1:0] v);
    return SW'(v);
  endfunction

  // Request capture: next-state then register.
  always_comb begin
    start   = req && !busy_q;
    wr_nxt  = start ? req_wr       : wr_q;
    len_nxt = start ? req_beats_m1 : len_q;
    sel_nxt = start ? req_cs       : sel_q;
    be_nxt  = start ? req_be       : be_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      wr_q  <= 1'b0;
      len_q <= '0;
      sel_q <= '0;
      be_q  <= '0;
    end else if (start) begin
      wr_q  <= wr_nxt;
      len_q <= len_nxt;
      sel_q <= sel_nxt;
      be_q  <= be_nxt;
    end
  end

  // Scaled window edges for the access that owns the next tick.
  always_comb begin
    scale   = SW'(cfg_gran) + SW'(1);
    ext     = SW'(len_nxt) * zx(cfg_beat_step);
    cyc_raw = ((wr_nxt ? zx(cfg_wr_cycle) : zx(cfg_rd_cycle)) + ext) * scale;
    end_tick = (cyc_raw == '0) ? SW'(1) : cyc_raw;

    on_a[SLOT_CS]   = zx(cfg_cs_on) * scale;
    off_a[SLOT_CS]  = ((wr_nxt ? zx(cfg_cs_wr_off) : zx(cfg_cs_rd_off)) + ext) * scale;
    on_a[SLOT_ADV]  = zx(cfg_adv_on) * scale;
    off_a[SLOT_ADV] = (wr_nxt ? zx(cfg_adv_wr_off) : zx(cfg_adv_rd_off)) * scale;
    on_a[SLOT_OE]   = zx(cfg_oe_on) * scale;
    off_a[SLOT_OE]  = zx(cfg_oe_off) * scale;
    on_a[SLOT_WE]   = zx(cfg_we_on) * scale;
    off_a[SLOT_WE]  = zx(cfg_we_off) * scale;
    on_a[SLOT_DIR]  = zx(cfg_oe_on) * scale;
    off_a[SLOT_DIR] = end_tick;

    en_a[SLOT_CS]  = 1'b1;
    en_a[SLOT_ADV] = 1'b1;
    en_a[SLOT_OE]  = !wr_nxt;
    en_a[SLOT_WE]  = wr_nxt;
    en_a[SLOT_DIR] = !wr_nxt;

    half_a[SLOT_CS]  = cfg_half_dly[0];
    half_a[SLOT_ADV] = cfg_half_dly[1];
    half_a[SLOT_OE]  = cfg_half_dly[2];
    half_a[SLOT_WE]  = cfg_half_dly[3];
    half_a[SLOT_DIR] = cfg_half_dly[2];
  end

  strobe_tick_ctr #(.SW(SW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sn),
    .start    (start),
    .end_tick (end_tick),
    .busy_q   (busy_q),
    .busy_nxt (busy_nxt),
    .tick_nxt (tick_nxt),
    .done_q   (done)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_win
    strobe_win #(.SW(SW)) u_win (
      .clk      (clk),
      .rst_n    (rst_sn),
      .en       (en_a[s]),
      .busy_q   (busy_q),
      .busy_nxt (busy_nxt),
      .tick_nxt (tick_nxt),
      .on_t     (on_a[s]),
      .off_t    (off_a[s]),
      .half     (half_a[s]),
      .act      (act_a[s])
    );
  end

  for (genvar c = 0; c < NCS; c++) begin : g_cs
    assign cs_n[c] = !(act_a[SLOT_CS] && (sel_q == CSW'(c)));
  end

  assign adv_n  = !act_a[SLOT_ADV];
  assign oe_n   = !act_a[SLOT_OE];
  assign we_n   = !act_a[SLOT_WE];
  assign dir_in = act_a[SLOT_DIR];
  assign be_n   = busy_q ? ~be_q : {BEW{1'b1}};

  AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_sn)
    $countones(~cs_n) <= 1); // R8
  AST_BE_STEADY: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_q && $past(busy_q)) |-> $stable(be_n)); // R6
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_q && $past(busy_q)) |-> $stable(sel_q)); // R10
  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_q && !wr_q) |-> we_n); // R11
  AST_WRITE_NO_OE: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_q && wr_q) |-> (oe_n && !dir_in)); // R11
  AST_DIR_COVERS_OE: assert property (@(posedge clk) disable iff (!rst_sn)
    !oe_n |-> dir_in); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> (&cs_n && adv_n && oe_n && we_n && &be_n && !dir_in)); // R9
endmodule

// File: tb/mem_strobe_seq_test.sv
`timescale 1ns/100ps
module mem_strobe_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req = 0, req_wr = 0;
  logic [2:0] req_beats_m1 = 0;
  logic [1:0] req_cs = 0, req_be = 0;
  logic [1:0] cfg_gran = 0;
  logic [4:0] cfg_cs_on = 1, cfg_cs_rd_off = 8, cfg_cs_wr_off = 7;
  logic [4:0] cfg_adv_on = 1, cfg_adv_rd_off = 3, cfg_adv_wr_off = 4;
  logic [4:0] cfg_oe_on = 3, cfg_oe_off = 8, cfg_we_on = 2, cfg_we_off = 6;
  logic [4:0] cfg_rd_cycle = 9, cfg_wr_cycle = 8, cfg_beat_step = 2;
  logic [3:0] cfg_half_dly = 0;
  logic [3:0] cs_n;
  logic       adv_n, oe_n, we_n, dir_in, done;
  logic [1:0] be_n;

  mem_strobe_seq uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_beats_m1(req_beats_m1), .req_cs(req_cs), .req_be(req_be),
    .cfg_gran(cfg_gran), .cfg_cs_on(cfg_cs_on), .cfg_cs_rd_off(cfg_cs_rd_off),
    .cfg_cs_wr_off(cfg_cs_wr_off), .cfg_adv_on(cfg_adv_on),
    .cfg_adv_rd_off(cfg_adv_rd_off), .cfg_adv_wr_off(cfg_adv_wr_off),
    .cfg_oe_on(cfg_oe_on), .cfg_oe_off(cfg_oe_off), .cfg_we_on(cfg_we_on),
    .cfg_we_off(cfg_we_off), .cfg_rd_cycle(cfg_rd_cycle),
    .cfg_wr_cycle(cfg_wr_cycle), .cfg_beat_step(cfg_beat_step),
    .cfg_half_dly(cfg_half_dly), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n),
    .we_n(we_n), .be_n(be_n), .dir_in(dir_in), .done(done)
  );

  int total = 0, fails = 0;
  bit model_on = 0;

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  // Behavioural tick model: 0 cs, 1 adv, 2 oe, 3 we, 4 dir.
  int m_busy = 0, m_t = 0, m_wr = 0, m_len = 0, m_cs = 0, m_be = 0, m_done = 0;
  int cur[5], prv[5];

  function automatic int endv(int wr, int len);
    int g = int'(cfg_gran) + 1;
    int e = ((wr ? int'(cfg_wr_cycle) : int'(cfg_rd_cycle)) + len * int'(cfg_beat_step)) * g;
    return (e < 1) ? 1 : e;
  endfunction

  function automatic int inwin(int t, int lo, int hi);
    return (t >= lo && t < hi) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!model_on) begin
      m_busy = 0; m_done = 0;
      for (int k = 0; k < 5; k++) begin cur[k] = 0; prv[k] = 0; end
    end else begin
      int g, ext;
      for (int k = 0; k < 5; k++) prv[k] = cur[k];
      m_done = 0;
      if (m_busy != 0) begin
        if (m_t + 1 >= endv(m_wr, m_len)) begin m_busy = 0; m_t = 0; m_done = 1; end
        else m_t = m_t + 1;
      end else if (req) begin
        m_busy = 1; m_t = 0; m_wr = int'(req_wr); m_len = int'(req_beats_m1);
        m_cs = int'(req_cs); m_be = int'(req_be);
      end
      g = int'(cfg_gran) + 1;
      ext = m_len * int'(cfg_beat_step);
      for (int k = 0; k < 5; k++) cur[k] = 0;
      if (m_busy != 0) begin
        cur[0] = inwin(m_t, int'(cfg_cs_on) * g,
                       ((m_wr != 0 ? int'(cfg_cs_wr_off) : int'(cfg_cs_rd_off)) + ext) * g);
        cur[1] = inwin(m_t, int'(cfg_adv_on) * g,
                       (m_wr != 0 ? int'(cfg_adv_wr_off) : int'(cfg_adv_rd_off)) * g);
        if (m_wr == 0) begin
          cur[2] = inwin(m_t, int'(cfg_oe_on) * g, int'(cfg_oe_off) * g);
          cur[4] = inwin(m_t, int'(cfg_oe_on) * g, endv(m_wr, m_len));
        end else begin
          cur[3] = inwin(m_t, int'(cfg_we_on) * g, int'(cfg_we_off) * g);
        end
      end
    end
  end

  task automatic compare(input bit high_phase);
    int e[5];
    int hd[5];
    int csx;
    hd[0] = int'(cfg_half_dly[0]); hd[1] = int'(cfg_half_dly[1]);
    hd[2] = int'(cfg_half_dly[2]); hd[3] = int'(cfg_half_dly[3]);
    hd[4] = int'(cfg_half_dly[2]);
    for (int k = 0; k < 5; k++) e[k] = (high_phase && hd[k] != 0) ? prv[k] : cur[k];
    csx = (e[0] != 0) ? (~(1 << m_cs) & 4'hF) : 4'hF;
    chk("R1 R2 R4 R5 R8 cs_n", int'(cs_n), csx);
    chk("R1 R2 R5 adv_n", int'(adv_n), 1 - e[1]);
    chk("R1 R5 R11 oe_n", int'(oe_n), 1 - e[2]);
    chk("R1 R5 R11 we_n", int'(we_n), 1 - e[3]);
    chk("R7 dir_in", int'(dir_in), e[4]);
    chk("R6 be_n", int'(be_n), (m_busy != 0) ? (~m_be & 3) : 3);
    chk("R9 done", int'(done), m_done);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (model_on) compare(1'b1);
    #2.5;
    if (model_on) compare(1'b0);
  end

  // Drive a request for one cycle; return edges from accept to done.
  task automatic access(input bit wr, input int len, input int cs, input int be,
                        output int span);
    @(negedge clk); #1.5;
    req = 1; req_wr = wr; req_beats_m1 = 3'(len); req_cs = 2'(cs); req_be = 2'(be);
    @(posedge clk); #2;
    req = 0;
    span = 0;
    for (int n = 1; n < 400; n++) begin
      @(posedge clk); #1;
      if (done) begin span = n; break; end
    end
  endtask

  task automatic set_cfg(input int gran, input int hd);
    @(negedge clk); #1.5;
    cfg_gran = 2'(gran); cfg_half_dly = 4'(hd);
  endtask

  int span;

  initial begin
    #1000000;
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk("R12 cs_n reset", int'(cs_n), 4'hF);
    chk("R12 strobes reset", int'({adv_n, oe_n, we_n}), 7);
    chk("R12 be_n reset", int'(be_n), 3);
    chk("R12 dir/done reset", int'({dir_in, done}), 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    model_on = 1;

    set_cfg(0, 0);
    access(0, 0, 0, 3, span);
    chk("R3 read single length", span, 9);
    access(1, 0, 2, 1, span);
    chk("R3 write single length", span, 8);

    set_cfg(0, 4'hF);
    access(1, 0, 1, 2, span);
    chk("R5 write half delay length", span, 8);
    access(0, 0, 3, 1, span);
    chk("R5 read half delay length", span, 9);

    set_cfg(1, 4'b0101);
    access(0, 3, 2, 3, span);
    chk("R3 R4 read burst scaled length", span, (9 + 3 * 2) * 2);

    set_cfg(2, 4'b1010);
    access(1, 2, 3, 2, span);
    chk("R3 R4 write burst scaled length", span, (8 + 2 * 2) * 3);

    // R10: request mid-access is ignored
    set_cfg(0, 0);
    @(negedge clk); #1.5;
    req = 1; req_wr = 0; req_beats_m1 = 0; req_cs = 1; req_be = 1;
    @(posedge clk); #2; req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1.5;
    req = 1; req_wr = 1; req_cs = 3; req_be = 2;
    @(posedge clk); #2; req = 0;
    for (int n = 0; n < 20; n++) begin
      @(posedge clk); #1;
      if (done) break;
    end
    repeat (3) begin
      @(posedge clk); #1;
      chk("R10 no second access", int'({cs_n, be_n}), 6'h3F);
    end

    // Minimal cycle, back to back
    @(negedge clk); #1.5;
    cfg_rd_cycle = 1; cfg_cs_on = 0; cfg_cs_rd_off = 1; cfg_adv_on = 0;
    cfg_adv_rd_off = 1; cfg_oe_on = 0; cfg_oe_off = 1;
    access(0, 0, 2, 3, span);
    chk("R9 R3 one-tick access length", span, 1);
    access(0, 0, 1, 1, span);
    chk("R9 second one-tick access", span, 1);
    repeat (4) @(posedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule